// File: doc/BRIEF.md
# External Boundary Scan Control Generator

This block drives an optional boundary scan chain of any length that sits outside the core, for example a ring of scan cells around the pads of a packaged device. It watches the test access port's data-register state indications (capture, shift, update), the decoded current instruction and a flag that says this chain is the one addressed. From these it produces a test-mode enable, an update clock, a capture clock for internal testing, a separate capture clock for external testing, a pair of non-overlapping master/slave shift clocks and an active-low high-impedance control. It also carries serial data out to the external chain and brings the chain's serial output back toward TDO.

Everything runs on a fast system clock (`clk`). The TAP provides a one-cycle strobe `tck_rise` in that clock domain at each rising TCK edge. The block uses the strobe to split every TCK period into four fast-clock phases: master high, gap, slave high, gap. That split keeps the two shift clocks from ever overlapping. All outputs are registered, so each one follows its inputs by one `clk` cycle. When the chain is not selected, every control output stays at its inactive level.

Top module: `ext_bscan_ctrl`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, every output becomes 0 except `hiz_n`, which becomes 1.
- R2: One cycle after a cycle with `chain_sel`=1 and any of `ir_intest`, `ir_extest`, `ir_clamp`, `ir_clampz` high, `test_mode` is 1. Otherwise it is 0.
- R3: `upd_clk` is 1 exactly one cycle after a cycle with `chain_sel`=1 and `st_update`=1, and 0 otherwise.
- R4: `cap_clk_int` is 1 one cycle after `chain_sel`, `st_capture` and `ir_intest` are all 1. `cap_clk_ext` does the same with `ir_extest`. Neither pulses for the other's instruction.
- R5: A 2-bit phase counter is 0 in the cycle after `tck_rise` and then advances by one each cycle, wrapping. `shclk_m` is 1 one cycle after a cycle with `chain_sel`=1, `st_shift`=1 and phase 0.
- R6: `shclk_s` is 1 one cycle after a cycle with `chain_sel`=1, `st_shift`=1 and phase 2. Both shift clocks are 0 outside shift-DR and are never 1 together.
- R7: `hiz_n` is 0 one cycle after a cycle with `chain_sel`=1 and `ir_highz`=1, and 1 otherwise.
- R8: `ext_si` equals the previous cycle's `tdi_in` while `chain_sel` was 1, and 0 when it was 0.
- R9: `tdo_out` equals the previous cycle's `ext_so` while `chain_sel` was 1, and 0 when it was 0.
- R10: With `chain_sel`=0, no state or instruction input moves any control output away from its inactive level (0, or 1 for `hiz_n`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| tck_rise | input | 1 | One-cycle strobe at each TCK rising edge |
| chain_sel | input | 1 | This external chain is the selected data register |
| st_capture | input | 1 | TAP is in capture-DR |
| st_shift | input | 1 | TAP is in shift-DR |
| st_update | input | 1 | TAP is in update-DR |
| ir_intest | input | 1 | Internal-test instruction decoded |
| ir_extest | input | 1 | External-test instruction decoded |
| ir_clamp | input | 1 | Clamp instruction decoded |
| ir_clampz | input | 1 | Clamp-to-high-impedance instruction decoded |
| ir_highz | input | 1 | High-impedance instruction decoded |
| tdi_in | input | 1 | Serial data from TDI |
| ext_so | input | 1 | Serial output of the external chain |
| ext_si | output | 1 | Serial input to the external chain |
| tdo_out | output | 1 | Chain data forwarded toward TDO |
| test_mode | output | 1 | Switches external cells to test mode |
| upd_clk | output | 1 | Update clock |
| cap_clk_int | output | 1 | Capture clock for internal test |
| cap_clk_ext | output | 1 | Capture clock for external test |
| shclk_m | output | 1 | Master shift clock |
| shclk_s | output | 1 | Slave shift clock |
| hiz_n | output | 1 | Active-low high-impedance control |

## Verification
Every output is one register away from the inputs it decodes, so each result is due on the first rising edge after its stimulus. The bench changes inputs on the falling edge and samples on the next falling edge, which lands after exactly that one edge. The shift clocks need two edges after `tck_rise`: one to set the phase to 0 and one to register the clock. Their checks therefore start on the second falling edge after the strobe and then follow the four-phase pattern one sample per cycle.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  typedef struct packed {
    logic intest;
    logic extest;
    logic clamp;
    logic clampz;
    logic highz;
  } bsc_instr_t;

  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
  } bsc_state_t;
endpackage

// File: rtl/bsc_ctrl_dec.sv
module bsc_ctrl_dec
  import bsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sel,
  input  bsc_state_t st,
  input  bsc_instr_t ir,
  output logic       test_mode,
  output logic       upd_clk,
  output logic       cap_int,
  output logic       cap_ext,
  output logic       hiz_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      test_mode <= 1'b0;
      upd_clk   <= 1'b0;
      cap_int   <= 1'b0;
      cap_ext   <= 1'b0;
      hiz_n     <= 1'b1;
    end else begin
      test_mode <= sel & (ir.intest | ir.extest | ir.clamp | ir.clampz);
      upd_clk   <= sel & st.update;
      cap_int   <= sel & st.capture & ir.intest;
      cap_ext   <= sel & st.capture & ir.extest;
      hiz_n     <= ~(sel & ir.highz);
    end
  end

  // R3: update clock only follows a selected update-DR cycle
  a_r3_upd_source: assert property (@(posedge clk) disable iff (rst)
    upd_clk |-> $past(sel && st.update));
  // R4: capture clocks each need capture-DR
  a_r4_cap_needs_capture: assert property (@(posedge clk) disable iff (rst)
    (cap_int || cap_ext) |-> $past(sel && st.capture));
  // R7: high-impedance only for a selected HIGHZ instruction
  a_r7_hiz_source: assert property (@(posedge clk) disable iff (rst)
    !hiz_n |-> $past(sel && ir.highz));
  // R10: deselected chain leaves every control inactive
  a_r10_gated: assert property (@(posedge clk) disable iff (rst)
    $past(!sel) |-> (!test_mode && !upd_clk && !cap_int && !cap_ext && hiz_n));
endmodule

// File: rtl/bsc_shift_phase.sv
module bsc_shift_phase #(
  parameter int PH_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tck_rise,
  input  logic sel,
  input  logic shift,
  output logic shclk_m,
  output logic shclk_s
);
  localparam int NUM_PH = 1 << PH_W;
  localparam logic [PH_W-1:0] MASTER_PH = '0;
  localparam logic [PH_W-1:0] SLAVE_PH  = PH_W'(NUM_PH / 2);

  logic [PH_W-1:0] phase;
  logic            active;

  assign active = sel & shift;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= '0;
      shclk_m <= 1'b0;
      shclk_s <= 1'b0;
    end else begin
      phase   <= tck_rise ? '0 : phase + 1'b1;
      shclk_m <= active & (phase == MASTER_PH);
      shclk_s <= active & (phase == SLAVE_PH);
    end
  end

  // R6: master and slave clocks never overlap
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(shclk_m && shclk_s));
  // R6: both shift clocks low unless a selected shift-DR cycle preceded
  a_r6_low_outside_shift: assert property (@(posedge clk) disable iff (rst)
    (shclk_m || shclk_s) |-> $past(sel && shift));
  // R5: master pulse lasts a single fast cycle (gap follows)
  a_r5_master_single: assert property (@(posedge clk) disable iff (rst)
    shclk_m |=> !shclk_m);
endmodule

// File: rtl/bsc_serial_route.sv
module bsc_serial_route #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic tdi_in,
  input  logic ext_so,
  output logic ext_si,
  output logic tdo_out
);
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          ext_si  <= 1'b0;
          tdo_out <= 1'b0;
        end else begin
          ext_si  <= sel & tdi_in;
          tdo_out <= sel & ext_so;
        end
      end
      // R9: returned data only appears for a selected chain
      a_r9_tdo_gated: assert property (@(posedge clk) disable iff (rst)
        tdo_out |-> $past(sel && ext_so));
    end else begin : g_comb
      assign ext_si  = sel & tdi_in;
      assign tdo_out = sel & ext_so;
      logic unused_clk;
      assign unused_clk = clk ^ rst;
    end
  endgenerate
endmodule

// File: rtl/ext_bscan_ctrl.sv
module ext_bscan_ctrl
  import bsc_pkg::*;
#(
  parameter int PH_W       = 2,
  parameter bit REG_SERIAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic tck_rise,
  input  logic chain_sel,
  input  logic st_capture,
  input  logic st_shift,
  input  logic st_update,
  input  logic ir_intest,
  input  logic ir_extest,
  input  logic ir_clamp,
  input  logic ir_clampz,
  input  logic ir_highz,
  input  logic tdi_in,
  input  logic ext_so,
  output logic ext_si,
  output logic tdo_out,
  output logic test_mode,
  output logic upd_clk,
  output logic cap_clk_int,
  output logic cap_clk_ext,
  output logic shclk_m,
  output logic shclk_s,
  output logic hiz_n
);
  bsc_state_t st;
  bsc_instr_t ir;

  assign st = '{capture: st_capture, shift: st_shift, update: st_update};
  assign ir = '{intest: ir_intest, extest: ir_extest, clamp: ir_clamp,
                clampz: ir_clampz, highz: ir_highz};

  bsc_ctrl_dec u_dec (
    .clk       (clk),
    .rst       (rst),
    .sel       (chain_sel),
    .st        (st),
    .ir        (ir),
    .test_mode (test_mode),
    .upd_clk   (upd_clk),
    .cap_int   (cap_clk_int),
    .cap_ext   (cap_clk_ext),
    .hiz_n     (hiz_n)
  );

  bsc_shift_phase #(.PH_W(PH_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .tck_rise (tck_rise),
    .sel      (chain_sel),
    .shift    (st.shift),
    .shclk_m  (shclk_m),
    .shclk_s  (shclk_s)
  );

  bsc_serial_route #(.REG_OUT(REG_SERIAL)) u_ser (
    .clk     (clk),
    .rst     (rst),
    .sel     (chain_sel),
    .tdi_in  (tdi_in),
    .ext_so  (ext_so),
    .ext_si  (ext_si),
    .tdo_out (tdo_out)
  );

  // R2: test mode only for a selected test/clamp instruction
  a_r2_test_mode_src: assert property (@(posedge clk) disable iff (rst)
    test_mode |-> $past(chain_sel && (ir_intest || ir_extest || ir_clamp || ir_clampz)));
  // R4: capture clocks are mutually exclusive for one-hot instructions
  a_r4_cap_excl: assert property (@(posedge clk) disable iff (rst)
    $past(!(ir_intest && ir_extest)) |-> !(cap_clk_int && cap_clk_ext));
endmodule

// File: tb/ext_bscan_ctrl_tb_top.sv
module ext_bscan_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tck_rise = 0, chain_sel = 0, st_capture = 0, st_shift = 0, st_update = 0;
  logic ir_intest = 0, ir_extest = 0, ir_clamp = 0, ir_clampz = 0, ir_highz = 0;
  logic tdi_in = 0, ext_so = 0;
  logic ext_si, tdo_out, test_mode, upd_clk, cap_clk_int, cap_clk_ext;
  logic shclk_m, shclk_s, hiz_n;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  ext_bscan_ctrl dut_i (
    .clk(clk), .rst(rst), .tck_rise(tck_rise), .chain_sel(chain_sel),
    .st_capture(st_capture), .st_shift(st_shift), .st_update(st_update),
    .ir_intest(ir_intest), .ir_extest(ir_extest), .ir_clamp(ir_clamp),
    .ir_clampz(ir_clampz), .ir_highz(ir_highz), .tdi_in(tdi_in), .ext_so(ext_so),
    .ext_si(ext_si), .tdo_out(tdo_out), .test_mode(test_mode), .upd_clk(upd_clk),
    .cap_clk_int(cap_clk_int), .cap_clk_ext(cap_clk_ext), .shclk_m(shclk_m),
    .shclk_s(shclk_s), .hiz_n(hiz_n)
  );

  // inputs [17:7] = sel,cap,shift,upd,intest,extest,clamp,clampz,highz,tdi,ext_so
  // expected [6:0] = test_mode,upd_clk,cap_int,cap_ext,hiz_n,ext_si,tdo_out
  localparam int NV = 10;
  localparam logic [17:0] VEC [NV] = '{
    18'b1_1_0_0_1_0_0_0_0_0_0__1_0_1_0_1_0_0,  // R4 R2 intest capture
    18'b1_1_0_0_0_1_0_0_0_1_0__1_0_0_1_1_1_0,  // R4 R8 extest capture
    18'b1_0_0_1_0_0_1_0_0_0_1__1_1_0_0_1_0_1,  // R3 R9 clamp update
    18'b1_0_0_0_0_0_0_1_0_0_0__1_0_0_0_1_0_0,  // R2 clampz
    18'b1_0_0_1_0_0_0_0_1_0_0__0_1_0_0_0_0_0,  // R7 highz
    18'b0_1_0_1_1_0_0_0_0_1_1__0_0_0_0_1_0_0,  // R10 deselected
    18'b0_0_0_0_0_0_0_0_1_0_0__0_0_0_0_1_0_0,  // R10 highz deselected
    18'b1_1_0_0_0_0_0_0_0_0_0__0_0_0_0_1_0_0,  // R4 capture, no test instr
    18'b1_0_0_0_0_0_0_0_0_1_1__0_0_0_0_1_1_1,  // R8 R9 serial routing
    18'b0_0_0_0_0_0_1_1_0_0_0__0_0_0_0_1_0_0   // R10 clamp deselected
  };

  function automatic logic [6:0] outs();
    return {test_mode, upd_clk, cap_clk_int, cap_clk_ext, hiz_n, ext_si, tdo_out};
  endfunction

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [10:0] v);
    {chain_sel, st_capture, st_shift, st_update, ir_intest, ir_extest,
     ir_clamp, ir_clampz, ir_highz, tdi_in, ext_so} = v;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R1 reset", outs(), 7'b0000100);
    check("R1 reset shift", {5'b0, shclk_m, shclk_s}, 7'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][17:7]);
      @(negedge clk);
      check($sformatf("R2-vector %0d (R3 R4 R7 R8 R9 R10)", i), outs(), VEC[i][6:0]);
    end

    // R5 R6 four-phase shift clocks
    drive(11'b1_0_1_0_0_1_0_0_0_0_0);
    tck_rise = 1'b1;
    @(negedge clk);
    tck_rise = 1'b0;
    for (int rep = 0; rep < 2; rep++) begin
      @(negedge clk); check("R5 master phase", {5'b0, shclk_m, shclk_s}, 7'b0000010);
      @(negedge clk); check("R6 gap1", {5'b0, shclk_m, shclk_s}, 7'b0);
      @(negedge clk); check("R6 slave phase", {5'b0, shclk_m, shclk_s}, 7'b0000001);
      @(negedge clk); check("R6 gap2", {5'b0, shclk_m, shclk_s}, 7'b0);
    end

    // R6 low outside shift-DR
    st_shift = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); check("R6 no shift", {5'b0, shclk_m, shclk_s}, 7'b0);
    end

    // R10 shift while deselected
    st_shift = 1'b1; chain_sel = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); check("R10 shift deselected", {5'b0, shclk_m, shclk_s}, 7'b0);
    end

    // R5 tck_rise restarts phase mid-cycle
    chain_sel = 1'b1;
    @(negedge clk);
    tck_rise = 1'b1;
    @(negedge clk);
    tck_rise = 1'b0;
    @(negedge clk); check("R5 phase restart", {5'b0, shclk_m, shclk_s}, 7'b0000010);

    // R1 reset mid-operation
    drive(11'b1_1_0_1_1_0_0_0_1_1_1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset mid-run", outs(), 7'b0000100);
    check("R1 reset mid-run shift", {5'b0, shclk_m, shclk_s}, 7'b0);
    rst = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule